// File: doc/BRIEF.md
# Erased Page Read Detector

This block watches the data beats of a single page as it is read from NAND flash and decides whether the page is blank (freshly erased) or holds real data that the error corrector failed on. An erased page reads as almost all ones, so the block counts the zero bits in every beat. At the end of the page it compares the total against a programmable threshold. A total strictly below the threshold marks the page as a blank candidate.

With ECC switched off, the candidate flag alone decides the verdict, one cycle after the last beat. With ECC switched on, the block holds the candidate flag in a register. It then waits for the decoder's completion strobe, which may come any number of cycles later, and combines the flag with the decoder's uncorrectable indication. A blank page that the decoder called uncorrectable raises the erased-page event and suppresses the uncorrectable-error event. A page with data that the decoder called uncorrectable raises the uncorrectable-error event. Every verdict comes with a one-cycle page-done pulse. The following page may already stream in while a verdict is still pending.

Top module: `erased_page_detector`

## Requirements
- R1: A beat with `beat_valid` and `beat_first` high starts a new page total equal to that beat's own zero-bit count. Further valid beats add their zero-bit counts, where a zero bit is any bit of `beat_data` equal to 0.
- R2: The page total saturates at 2^CNT_W-1 (262143 by default) and never wraps.
- R3: A page counts as blank when its total, including the final beat, is strictly less than `erase_thresh`. The threshold is sampled in the cycle of the valid beat carrying `beat_last`.
- R4: If `ecc_enable` is low in the last-beat cycle, the cycle after it shows `page_done`=1, `erased_evt` equal to the blank flag, and `uncor_evt`=0.
- R5: If `ecc_enable` is high in the last-beat cycle, no output pulses until `ecc_done` is seen. The cycle after `ecc_done` shows `page_done`=1 and `erased_evt` = blank AND `ecc_uncorrectable`.
- R6: With ECC on and `ecc_uncorrectable` low at `ecc_done`, only `page_done` pulses, even for a blank page.
- R7: With ECC on, a non-blank page and `ecc_uncorrectable` high at `ecc_done`, `uncor_evt` pulses.
- R8: `erased_evt` and `uncor_evt` are never high together. Each is high only together with `page_done`, and each lasts one cycle per page.
- R9: `ecc_done` while no ECC verdict is pending has no effect on the outputs.
- R10: A synchronous active-high `rst` clears the total, any pending verdict and all outputs.
- R11: A pending verdict uses the held blank flag. Beats of the next page, including its first beat in the same cycle as `ecc_done`, do not change it. An ECC-off page must not end in the cycle in which `ecc_done` releases a pending verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| beat_valid | input | 1 | Beat qualifier |
| beat_first | input | 1 | Beat is the first of a page |
| beat_last | input | 1 | Beat is the last of a page |
| beat_data | input | 32 | Page data beat |
| erase_thresh | input | 18 | Blank-page zero-count threshold |
| ecc_enable | input | 1 | ECC in use for the page ending now |
| ecc_done | input | 1 | Decoder finished the pending page |
| ecc_uncorrectable | input | 1 | Decoder verdict, valid with ecc_done |
| page_done | output | 1 | Verdict pulse |
| erased_evt | output | 1 | Blank-page event pulse |
| uncor_evt | output | 1 | Uncorrectable-error event pulse |

## Verification
Two functions can fall in the same cycle. The decoder strobe releasing the held verdict of one page can coincide with the first beat, or the last beat, of the next ECC-protected page. The bench provokes both on purpose. It ends a page with ECC on, then asserts `ecc_done` in the very cycle that restarts the counter, and in another case in the cycle that closes a second page. It judges the released pulse against the flag of the earlier page and the later verdict against a total recomputed from the new beats only.

// File: rtl/erp_pkg.sv
package erp_pkg;
   // Verdict outputs packed as {page_done, erased, uncorrectable}
   typedef struct packed {
      logic done;
      logic erased;
      logic uncor;
   } erp_verdict_t;
endpackage

// File: rtl/erp_zero_counter.sv
module erp_zero_counter #(
   parameter int BEAT_W = 32,
   parameter int CNT_W  = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid,
   input  logic              first,
   input  logic [BEAT_W-1:0] data,
   output logic [CNT_W-1:0]  total_now
);
   localparam int ZW = $clog2(BEAT_W + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (BEAT_W < 1) begin : g_bad_beat
         $error("BEAT_W must be positive");
      end
      if (CNT_W < ZW) begin : g_bad_cnt
         $error("CNT_W too narrow for one beat");
      end
   endgenerate

   logic [BEAT_W-1:0] zbit;
   logic [ZW-1:0]     zeros;
   logic [CNT_W-1:0]  acc_q;
   logic [CNT_W-1:0]  base;
   logic [CNT_W:0]    sum_ext;

   genvar gi;
   generate
      for (gi = 0; gi < BEAT_W; gi++) begin : g_zbit
         assign zbit[gi] = ~data[gi];
      end
   endgenerate

   always_comb begin
      zeros = '0;
      for (int i = 0; i < BEAT_W; i++) begin
         zeros = zeros + ZW'(zbit[i]);
      end
   end

   assign base    = first ? '0 : acc_q;
   assign sum_ext = {1'b0, base} + (CNT_W+1)'(zeros);
   assign total_now = sum_ext[CNT_W] ? CNT_MAX : sum_ext[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (rst)        acc_q <= '0;
      else if (valid) acc_q <= total_now;
   end

   p_sat_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (valid && !first && acc_q == CNT_MAX) |=> acc_q == CNT_MAX);

   p_first_clears_r1: assert property (@(posedge clk) disable iff (rst)
      (valid && first) |=> acc_q <= CNT_W'(BEAT_W));

   p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      (valid && !first) |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/erp_verdict.sv
module erp_verdict
   import erp_pkg::*;
(
   input  logic         clk,
   input  logic         rst,
   input  logic         end_stb,
   input  logic         blank,
   input  logic         ecc_en,
   input  logic         ecc_done,
   input  logic         ecc_uncor,
   output erp_verdict_t vout
);
   logic pend_q;
   logic held_q;
   logic release_now;
   logic direct_now;

   assign release_now = pend_q & ecc_done;
   assign direct_now  = end_stb & ~ecc_en;

   always_ff @(posedge clk) begin
      if (rst) begin
         vout   <= '0;
         pend_q <= 1'b0;
         held_q <= 1'b0;
      end else begin
         vout <= '0;
         if (release_now) begin
            vout.done   <= 1'b1;
            vout.erased <= held_q & ecc_uncor;
            vout.uncor  <= ~held_q & ecc_uncor;
         end else if (direct_now) begin
            vout.done   <= 1'b1;
            vout.erased <= blank;
         end
         if (end_stb && ecc_en) begin
            pend_q <= 1'b1;
            held_q <= blank;
         end else if (release_now) begin
            pend_q <= 1'b0;
         end
      end
   end

   p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
      !(vout.erased && vout.uncor));

   p_evt_with_done_r8: assert property (@(posedge clk) disable iff (rst)
      (vout.erased || vout.uncor) |-> vout.done);

   p_release_r5: assert property (@(posedge clk) disable iff (rst)
      (pend_q && ecc_done) |=> vout.done);

   p_noecc_no_uncor_r4: assert property (@(posedge clk) disable iff (rst)
      (direct_now && !pend_q) |=> (vout.done && !vout.uncor));

   p_stray_done_r9: assert property (@(posedge clk) disable iff (rst)
      (ecc_done && !pend_q && !direct_now) |=> !vout.done);
endmodule

// File: rtl/erased_page_detector.sv
module erased_page_detector
   import erp_pkg::*;
#(
   parameter int BEAT_W = 32,
   parameter int CNT_W  = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              beat_valid,
   input  logic              beat_first,
   input  logic              beat_last,
   input  logic [BEAT_W-1:0] beat_data,
   input  logic [CNT_W-1:0]  erase_thresh,
   input  logic              ecc_enable,
   input  logic              ecc_done,
   input  logic              ecc_uncorrectable,
   output logic              page_done,
   output logic              erased_evt,
   output logic              uncor_evt
);
   logic [CNT_W-1:0] total_now;
   logic             end_stb;
   logic             blank;
   erp_verdict_t     vout;

   erp_zero_counter #(.BEAT_W(BEAT_W), .CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .valid     (beat_valid),
      .first     (beat_first),
      .data      (beat_data),
      .total_now (total_now)
   );

   assign end_stb = beat_valid & beat_last;
   assign blank   = total_now < erase_thresh;

   erp_verdict u_vrd (
      .clk       (clk),
      .rst       (rst),
      .end_stb   (end_stb),
      .blank     (blank),
      .ecc_en    (ecc_enable),
      .ecc_done  (ecc_done),
      .ecc_uncor (ecc_uncorrectable),
      .vout      (vout)
   );

   assign page_done  = vout.done;
   assign erased_evt = vout.erased;
   assign uncor_evt  = vout.uncor;

   p_reset_quiet_r10: assert property (@(posedge clk)
      $past(rst) |-> !(page_done || erased_evt || uncor_evt));
endmodule

// File: tb/erased_page_detector_bench.sv
`timescale 1ns/100ps
module erased_page_detector_bench;
   localparam int BW = 32;
   localparam int CW = 18;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 0;
   logic rst = 1;
   logic bv = 0, bf = 0, bl = 0;
   logic [BW-1:0] bd = '1;
   logic [CW-1:0] thr = '0;
   logic ecc_en = 0, edone = 0, euncor = 0;
   logic page_done, erased_evt, uncor_evt;

   int n_vec = 0;
   int n_bad = 0;
   logic [BW-1:0] beats [8];

   always #2.5 clk = ~clk;

   erased_page_detector u_erased_page_detector (
      .clk(clk), .rst(rst), .beat_valid(bv), .beat_first(bf), .beat_last(bl),
      .beat_data(bd), .erase_thresh(thr), .ecc_enable(ecc_en), .ecc_done(edone),
      .ecc_uncorrectable(euncor), .page_done(page_done), .erased_evt(erased_evt),
      .uncor_evt(uncor_evt));

   function automatic int zc(logic [BW-1:0] d);
      return $countones(~d);
   endfunction

   function automatic int sat_add(int a, int b);
      return (a + b > CMAX) ? CMAX : a + b;
   endfunction

   function automatic logic [BW-1:0] gen_beat(int mode);
      logic [BW-1:0] d;
      if (mode == 0) begin
         d = '1;
         if ($urandom_range(0, 2) == 0) d[$urandom_range(0, BW-1)] = 1'b0;
      end else begin
         d = $urandom;
      end
      return d;
   endfunction

   task automatic chk(string tag, logic [2:0] exp);
      logic [2:0] act;
      act = {page_done, erased_evt, uncor_evt};
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {done,erased,uncor} got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // drive one cycle, then sample just after the capturing edge
   task automatic cyc(logic v, logic f, logic l, logic [BW-1:0] d, logic ed, logic eu);
      bv = v; bf = f; bl = l; bd = d; edone = ed; euncor = eu;
      @(posedge clk);
      #1;
      bv = 0; bf = 0; bl = 0; edone = 0;
   endtask

   // ECC done without a following page in the same cycle
   task automatic release_and_check(string tag, bit blank_flag, bit u);
      cyc(0, 0, 0, '1, 1, u);
      chk(tag, {1'b1, blank_flag & u, ~blank_flag & u});
   endtask

   // stream a page; returns blank flag; checks ECC-off verdict / ECC-on silence
   task automatic run_page(int len, bit ecc, int thr_sel, output bit blank_flag);
      int total;
      total = 0;
      for (int i = 0; i < len; i++) begin
         beats[i] = gen_beat($urandom_range(0, 3) == 0 ? 1 : 0);
         total = sat_add(total, zc(beats[i]));
      end
      case (thr_sel)
         0: thr = CW'(total);
         1: thr = CW'(total + 1);
         default: thr = CW'($urandom_range(0, 40));
      endcase
      blank_flag = total < int'(thr);
      ecc_en = ecc;
      for (int i = 0; i < len; i++) begin
         cyc(1, i == 0, i == len - 1, beats[i], 0, 0);
         if (i < len - 1) chk("R1 mid-page quiet", 3'b000);
      end
      if (!ecc) chk("R3/R4 ecc-off verdict", {1'b1, blank_flag, 1'b0});
      else      chk("R5 ecc-on waits", 3'b000);
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      bit b, b2;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset state", 3'b000);
      rst = 0;

      // R1/R3 directed: one all-ones beat, threshold 1 -> blank
      thr = 1; ecc_en = 0;
      cyc(1, 1, 1, '1, 0, 0);
      chk("R1 single beat blank", 3'b110);
      // threshold equal to count -> not blank (strict)
      thr = 3;
      cyc(1, 1, 0, 32'hFFFF_FFFE, 0, 0);
      cyc(1, 0, 1, 32'hFFFF_FFFC, 0, 0);
      chk("R3 equal not blank", 3'b100);
      // first clears: previous total 3 discarded
      thr = 1;
      cyc(1, 1, 1, '1, 0, 0);
      chk("R1 first clears", 3'b110);

      // R9: stray ecc_done
      cyc(0, 0, 0, '1, 1, 1);
      chk("R9 stray ecc_done ignored", 3'b000);

      // R6: ECC on, blank, correctable -> only done
      thr = 5; ecc_en = 1;
      cyc(1, 1, 1, '1, 0, 0);
      chk("R5 pending", 3'b000);
      cyc(0, 0, 0, '1, 0, 0);
      chk("R5 still pending", 3'b000);
      release_and_check("R6 clean blank", 1'b1, 1'b0);
      // R5: blank + uncorrectable -> erased only
      cyc(1, 1, 1, '1, 0, 0);
      release_and_check("R5/R8 blank uncor", 1'b1, 1'b1);
      // R7: not blank + uncorrectable
      thr = 2;
      cyc(1, 1, 1, 32'h0000_FFFF, 0, 0);
      release_and_check("R7 data uncor", 1'b0, 1'b1);
      cyc(0, 0, 0, '1, 0, 0);
      chk("R8 single pulse", 3'b000);

      // R11: release coincides with first beat of next page
      thr = 4; ecc_en = 1;
      cyc(1, 1, 1, '1, 0, 0);                      // page A blank
      thr = 4;
      cyc(1, 1, 0, 32'h0000_0000, 1, 1);           // ecc_done for A + B first
      chk("R11 release with first beat", 3'b110);
      cyc(1, 0, 1, '1, 0, 0);                      // B total 32 -> not blank
      chk("R11 next page pending", 3'b000);
      // release B in same cycle as C's last (ECC on)
      cyc(1, 1, 1, '1, 1, 1);                      // C blank (0 < 4)
      chk("R11 release with last beat", 3'b101);
      release_and_check("R11 held flag of later page", 1'b1, 1'b1);

      // R10: reset drops a pending verdict
      cyc(1, 1, 1, '1, 0, 0);
      rst = 1;
      cyc(0, 0, 0, '1, 0, 0);
      rst = 0;
      chk("R10 reset mid-pending", 3'b000);
      cyc(0, 0, 0, '1, 1, 1);
      chk("R10 pending cleared", 3'b000);

      // R2: saturation with 8200 all-zero beats, threshold at max
      thr = CW'(CMAX); ecc_en = 0;
      for (int i = 0; i < 8200; i++) cyc(1, i == 0, i == 8199, '0, 0, 0);
      chk("R2 saturated not below max", 3'b100);

      // random pages
      for (int p = 0; p < 300; p++) begin
         bit e;
         e = $urandom_range(0, 1);
         run_page($urandom_range(1, 8), e, $urandom_range(0, 2), b);
         if (e) begin
            for (int g = $urandom_range(0, 4); g > 0; g--) begin
               cyc(0, 0, 0, '1, 0, 0);
               chk("R5 gap quiet", 3'b000);
            end
            b2 = $urandom_range(0, 1);
            release_and_check("R5/R6/R7 random", b, b2);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule